// File: doc/BRIEF.md
# PCM Bit Clock and Frame Sync Generator

This block produces the serial bit clock and the one-bit-wide frame sync for a PCM audio data port. It runs in a single clock domain. Two clock-enable strobes stand in for the two possible source clocks. A control word picks one of them and sets two dividers: one for the bit-clock half period and one for the number of bit clocks in a frame. A run bit starts and stops the generator.

Beside the bit clock and frame sync, the block gives the data port a bit-index counter and two single-cycle strobes. Each strobe flags the system clock edge on which the bit clock is about to rise or fall, so a shifter can launch data or sample it without edge-detecting the bit clock. Divider values written while the generator runs take effect only at the next frame boundary, so a frame is never cut short.

Top module: `pcm_clkgen`

## Requirements
- R1: After reset, `bclk`, `fsync`, both strobes and `bit_idx` are all zero.
- R2: While `ctrl[19]` (run) is 0, the generator is stopped. From the next clock edge on, `bclk` is low, `fsync` is low and `bit_idx` is 0.
- R3: `ctrl[18]` picks the source strobe. When it is 1 the generator counts `bus_ce`; when it is 0 it counts `aud_ce`. The strobe that is not selected has no effect on `bclk`.
- R4: Each half period of `bclk` lasts `ctrl[17:9]`+1 selected source strobes, so the full period is 2×(`ctrl[17:9]`+1) strobes. Every bit starts with its low half.
- R5: A frame lasts `ctrl[8:0]`+1 bit periods. `bit_idx` counts 0 up to `ctrl[8:0]` and steps on each falling edge of `bclk`.
- R6: `fsync` is high for exactly one bit period at the start of each frame, which is the bit with `bit_idx` = 0.
- R7: The first cycle after run goes from 0 to 1 starts a fresh frame: `fsync` is 1, `bit_idx` is 0 and `bclk` is low.
- R8: A change to `ctrl[17:0]` made while running takes effect at the next frame boundary. The frame in progress keeps its old lengths.
- R9: `bclk_rise_stb` is high exactly in the cycle whose clock edge drives `bclk` high, and `bclk_fall_stb` in the cycle whose edge drives it low. Each bit has one of each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ce | input | 1 | Clock-enable strobe of the bus clock source |
| aud_ce | input | 1 | Clock-enable strobe of the audio clock source |
| ctrl | input | 20 | Bit 19 run, bit 18 source select, bits 17:9 half-period divider, bits 8:0 frame divider |
| bclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame sync, high during bit 0 of each frame |
| bit_idx | output | 9 | Index of the current bit within the frame |
| bclk_rise_stb | output | 1 | High in the cycle before `bclk` rises |
| bclk_fall_stb | output | 1 | High in the cycle before `bclk` falls |

## Verification
A wrong half-period count shows up within one bit period as a `bclk` period that is not 2×(divider+1) source strobes. A wrong bit counter or a divider latched at the wrong time shows up within one or two frames as a wrong spacing between `fsync` rises, or as a wrong peak value of `bit_idx`. A stop path that fails to clear its state shows up one cycle after run drops, as a non-zero `bclk` or index, or as a restart that does not open with `fsync` high. Each of these is measured against the control word over whole frames, for both sources and for the default frame length.

// File: rtl/pcm_clkgen.sv
module pcm_clkgen #(
  parameter int DIV_W  = 9,
  parameter int SYNC_W = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_ce,
  input  logic                        aud_ce,
  input  logic [DIV_W+SYNC_W+1:0]     ctrl,
  output logic                        bclk,
  output logic                        fsync,
  output logic [SYNC_W-1:0]           bit_idx,
  output logic                        bclk_rise_stb,
  output logic                        bclk_fall_stb
);
  localparam int EN_B  = DIV_W + SYNC_W + 1;
  localparam int SEL_B = DIV_W + SYNC_W;

  logic              run;
  logic [DIV_W-1:0]  hcnt, hdiv_q;
  logic [SYNC_W-1:0] sdiv_q;

  wire              en       = ctrl[EN_B];
  wire              tick     = ctrl[SEL_B] ? bus_ce : aud_ce;
  wire [DIV_W-1:0]  hdiv_new = ctrl[SEL_B-1:SYNC_W];
  wire [SYNC_W-1:0] sdiv_new = ctrl[SYNC_W-1:0];
  wire              half_end = en & run & tick & (hcnt == hdiv_q);
  wire              last_bit = (bit_idx == sdiv_q);

  assign bclk_rise_stb = half_end & ~bclk;
  assign bclk_fall_stb = half_end & bclk;
  assign fsync         = run & (bit_idx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      bclk    <= 1'b0;
      hcnt    <= '0;
      bit_idx <= '0;
      hdiv_q  <= '0;
      sdiv_q  <= '0;
    end else begin
      run <= en;
      if (!en || !run) begin
        bclk    <= 1'b0;
        hcnt    <= '0;
        bit_idx <= '0;
        hdiv_q  <= hdiv_new;
        sdiv_q  <= sdiv_new;
      end else if (tick) begin
        if (hcnt == hdiv_q) begin
          hcnt <= '0;
          bclk <= ~bclk;
          if (bclk) begin
            if (last_bit) begin
              bit_idx <= '0;
              hdiv_q  <= hdiv_new;
              sdiv_q  <= sdiv_new;
            end else begin
              bit_idx <= bit_idx + 1'b1;
            end
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end

  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk && !fsync && bit_idx == '0));

  a_r4_bclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(bclk)) |-> $past(tick));

  a_r4_hcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= hdiv_q);

  a_r5_idx_steps_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(bit_idx)) |-> $fell(bclk));

  a_r5_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= sdiv_q);

  a_r6_fsync_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fsync) && $past(run)) |-> $fell(bclk));

  a_r9_rise_stb: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise_stb |=> bclk);

  a_r9_fall_stb: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall_stb |=> !bclk);

  a_r9_stb_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bclk_rise_stb, bclk_fall_stb}));
endmodule

// File: tb/pcm_clkgen_tb.sv
module pcm_clkgen_tb;
  localparam int CLK_P   = 10;
  localparam int AUD_DIV = 3;
  localparam int NV      = 4;
  // sel, half-period divider, frame divider
  localparam int VEC [NV][3] = '{'{1, 0, 3}, '{1, 2, 7}, '{0, 1, 4}, '{1, 0, 127}};

  logic clk = 1'b0, rst_n = 1'b0, bus_ce = 1'b1, aud_gate = 1'b1;
  logic [19:0] ctrl = '0;
  logic aud_ce, bclk, fsync, rstb, fstb;
  logic [8:0] bit_idx;
  int acnt = 0;
  int nchk = 0, nfail = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) acnt <= (acnt == AUD_DIV-1) ? 0 : acnt + 1;
  assign aud_ce = aud_gate && (acnt == 0);

  pcm_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .aud_ce(aud_ce), .ctrl(ctrl),
    .bclk(bclk), .fsync(fsync), .bit_idx(bit_idx),
    .bclk_rise_stb(rstb), .bclk_fall_stb(fstb)
  );

  int cyc = 0, fs_rises = 0, t_prev = 0, t_last = 0, fs_w = 0, fs_w_last = 0;
  int bc_t = 0, bc_per = 0, bc_rises = 0, acc_r = 0, acc_max = 0, r_frame = 0, max_frame = 0;
  logic fs_q = 1'b0, bc_q = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (fsync && !fs_q) begin
      fs_rises++; t_prev = t_last; t_last = cyc;
      r_frame = acc_r; max_frame = acc_max; acc_r = 0; acc_max = 0; fs_w = 0;
    end
    if (fsync) fs_w++;
    else if (fs_q) fs_w_last = fs_w;
    if (bclk && !bc_q) begin bc_rises++; bc_per = cyc - bc_t; bc_t = cyc; end
    if (rstb) acc_r++;
    if (int'(bit_idx) > acc_max) acc_max = int'(bit_idx);
    fs_q = fsync; bc_q = bclk;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_ctrl(logic en, logic sel, int bd, int sd);
    @(negedge clk);
    ctrl <= {en, sel, 9'(bd), 9'(sd)};
  endtask

  task automatic wait_rises(int n);
    int s = fs_rises;
    while (fs_rises < s + n) @(posedge clk);
  endtask

  initial begin
    #(CLK_P * 190000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int t0, t1, b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 bclk", int'(bclk), 0);
    chk("R1 fsync", int'(fsync), 0);
    chk("R1 bit_idx", int'(bit_idx), 0);
    chk("R1 strobes", int'(rstb | fstb), 0);
    rst_n <= 1'b1;

    for (int v = 0; v < NV; v++) begin
      int sel = VEC[v][0], bd = VEC[v][1], sd = VEC[v][2];
      int p = 2 * (bd + 1) * (sel != 0 ? 1 : AUD_DIV);
      set_ctrl(1'b0, 1'(sel), bd, sd);
      repeat (3) @(negedge clk);
      set_ctrl(1'b1, 1'(sel), bd, sd);
      wait_rises(3);
      chk("R3 R4 bclk period", bc_per, p);
      chk("R5 frame length", t_last - t_prev, (sd + 1) * p);
      chk("R5 bit_idx peak", max_frame, sd);
      chk("R6 fsync width", fs_w_last, p);
      chk("R9 rise strobes per frame", r_frame, sd + 1);
    end

    // R2 stop holds outputs low
    set_ctrl(1'b1, 1'b1, 1, 5);
    wait_rises(2);
    repeat (3) @(negedge clk);
    ctrl[19] <= 1'b0;
    @(negedge clk);
    chk("R2 bclk after stop", int'(bclk), 0);
    chk("R2 fsync after stop", int'(fsync), 0);
    chk("R2 bit_idx after stop", int'(bit_idx), 0);
    b0 = bc_rises;
    repeat (20) @(negedge clk);
    chk("R2 no bclk rises while stopped", bc_rises - b0, 0);

    // R7 restart opens a fresh frame
    ctrl[19] <= 1'b1;
    @(negedge clk);
    chk("R7 fsync at restart", int'(fsync), 1);
    chk("R7 bit_idx at restart", int'(bit_idx), 0);
    chk("R7 bclk low at restart", int'(bclk), 0);

    // R3 unselected strobe ignored, selected one gated off
    set_ctrl(1'b0, 1'b0, 0, 3);
    aud_gate <= 1'b0;
    set_ctrl(1'b1, 1'b0, 0, 3);
    b0 = bc_rises;
    repeat (40) @(negedge clk);
    chk("R3 audio source gated, bus strobe ignored", bc_rises - b0, 0);
    ctrl[18] <= 1'b1;
    b0 = bc_rises;
    repeat (40) @(negedge clk);
    chk("R3 bus source drives bclk", bc_rises - b0, 20);
    aud_gate <= 1'b1;

    // R8 divider change applies at next boundary
    set_ctrl(1'b0, 1'b1, 0, 3);
    set_ctrl(1'b1, 1'b1, 0, 3);
    wait_rises(2);
    t0 = t_last;
    @(negedge clk);
    ctrl[17:0] <= {9'd1, 9'd7};
    wait_rises(1);
    t1 = t_last;
    chk("R8 current frame keeps old length", t1 - t0, 8);
    wait_rises(1);
    chk("R8 next frame uses new dividers", t_last - t1, 32);

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule